// File: doc/BRIEF.md
# Soft Interrupt Level Controller

This block keeps a 32-bit software interrupt register and merges it with sixteen external interrupt-level lines and three tick-compare match events. From the merged vector it derives one prioritized interrupt request for a processor core. The request is presented as a trap index: 0x40 plus the winning level. A one-cycle assert pulse marks each change of the claimed level, and a one-cycle deassert pulse marks its release. A separate wake pulse fires whenever any external line rises, so a halted core can resume.

Software changes the register through three privileged operations: set bits, clear bits and overwrite. Each takes as operand the XOR of two 64-bit sources, cut to the low 32 bits. A read port returns the register sign-extended to 64 bits.

The core can post a trap of another kind. While such a trap is posted, the block neither claims nor releases the request. The arbiter has three states:
- ARB_IDLE: nothing is posted.
- ARB_CLAIMED: an external-interrupt index is posted.
- ARB_FOREIGN: another trap is posted.

The arbiter has these transitions:
- claim: ARB_IDLE to ARB_CLAIMED.
- re-level: ARB_CLAIMED to ARB_CLAIMED with a new level.
- release: ARB_CLAIMED to ARB_IDLE.
- foreign post: any state to ARB_FOREIGN.
- post clear: any state to ARB_IDLE.

Timing is fixed. The register and the line copies update on the clock edge that samples their inputs. The arbiter acts on the next edge.

Top module: `soft_irq_ctrl`

## Requirements
- R1: Operation encoding on `sw_op`: 0 does nothing, 1 sets, 2 clears and 3 writes. The operand is (`sw_src_a` XOR `sw_src_b`) truncated to 32 bits. Set ORs the operand into the register, clear ANDs in its inverse, and write replaces the register. The register updates on the next edge.
- R2: A nonzero `sw_op` with `sw_supervisor` low leaves the register unchanged. It also raises `sw_illegal` for exactly the cycle after that edge.
- R3: `rd_data` is the register sign-extended from bit 31 to 64 bits.
- R4: A match on any `tick_match` bit sets register bit 0 (the timer bit). When a match and a software operation fall in the same cycle, bit 0 still ends up set.
- R5: The pending vector is the external line copies ORed with the register with bit 0 cleared, ORed with the timer bit moved to level 14.
- R6: An external line's pending bit follows the line, one edge late. Raising the line sets the bit and lowering it clears the bit.
- R7: `wake` pulses for one cycle after any edge that samples a rising external line.
- R8: Levels 15 down to 1 are scanned and the highest set level wins. A nonzero pending vector with none of levels 1 to 15 set neither claims nor releases the request.
- R9: In ARB_IDLE or ARB_CLAIMED, a winning level L posts `trap_idx` = 0x40 + L. `irq_assert` pulses only when the posted index changes.
- R10: In ARB_CLAIMED, an all-zero pending vector returns `trap_idx` to 0 and pulses `irq_deassert`.
- R11: `other_post` loads `other_idx` and enters ARB_FOREIGN. There `trap_idx` stays fixed until `post_clear` returns the arbiter to ARB_IDLE. `post_clear` has priority over `other_post`, and both have priority over arbitration. `other_idx` is nonzero and outside 0x40 to 0x4F.
- R12: Reset clears the register, the line copies, the posted index and all pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_op | input | 2 | Software operation: 0 none, 1 set, 2 clear, 3 write |
| sw_src_a | input | 64 | First operand source |
| sw_src_b | input | 64 | Second operand source |
| sw_supervisor | input | 1 | High when the issuing mode is privileged |
| tick_match | input | 3 | Match events from the three tick comparators |
| ext_level | input | 16 | External interrupt-level lines |
| other_post | input | 1 | Core posts a trap of another kind |
| other_idx | input | 9 | Index of that other trap |
| post_clear | input | 1 | Core has taken the posted trap |
| rd_data | output | 64 | Register, sign-extended |
| sw_illegal | output | 1 | Illegal-instruction flag, one cycle |
| trap_idx | output | 9 | Posted trap index |
| irq_assert | output | 1 | Request (re)asserted, one cycle |
| irq_deassert | output | 1 | Request released, one cycle |
| wake | output | 1 | Wake pulse on a rising external line |

## Verification
The arbitration is tried with several pending sources. These are a lone register bit, a lone external line, both together, and a timer match that must outrank lower levels. Together they show the level-14 remap and the highest-wins order. Vectors with only bit 0 of the lines, or only register bits above 15, separate "nonzero" from "has a level": the request must be neither claimed nor dropped. Rising, falling and re-levelled line patterns show that the assert pulse marks index changes only. A posted foreign trap shows that claiming and releasing are both frozen until the post is cleared.

// File: rtl/soft_irq_pkg.sv
package soft_irq_pkg;

    typedef enum logic [1:0] {
        SW_NONE  = 2'd0,
        SW_SET   = 2'd1,
        SW_CLEAR = 2'd2,
        SW_WRITE = 2'd3
    } sw_op_e;

    typedef enum logic [1:0] {
        ARB_IDLE    = 2'd0,
        ARB_CLAIMED = 2'd1,
        ARB_FOREIGN = 2'd2
    } arb_state_e;

endpackage

// File: rtl/softint_reg.sv
module softint_reg
    import soft_irq_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int SRC_W    = 64,
    parameter int NUM_TICK = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          op,
    input  logic [SRC_W-1:0]    src_a,
    input  logic [SRC_W-1:0]    src_b,
    input  logic                supervisor,
    input  logic [NUM_TICK-1:0] tick_match,
    output logic [REG_W-1:0]    sreg_q,
    output logic                illegal_q
);

    sw_op_e          op_e;
    logic [REG_W-1:0] operand;
    logic [REG_W-1:0] sreg_d;
    logic             illegal_d;

    assign op_e    = sw_op_e'(op);
    assign operand = REG_W'(src_a ^ src_b);

    always_comb begin
        sreg_d    = sreg_q;
        illegal_d = 1'b0;
        if (op_e != SW_NONE && !supervisor) begin
            illegal_d = 1'b1;
        end else begin
            unique case (op_e)
                SW_NONE:  sreg_d = sreg_q;
                SW_SET:   sreg_d = sreg_q | operand;
                SW_CLEAR: sreg_d = sreg_q & ~operand;
                SW_WRITE: sreg_d = operand;
                default:  sreg_d = sreg_q;
            endcase
        end
        if (|tick_match) begin
            sreg_d[0] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q    <= '0;
            illegal_q <= 1'b0;
        end else begin
            sreg_q    <= sreg_d;
            illegal_q <= illegal_d;
        end
    end

    // R2
    priv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op != 2'd0 && !supervisor && tick_match == '0) |=> $stable(sreg_q));

    // R4
    timer_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|tick_match) |=> sreg_q[0]);

endmodule

// File: rtl/level_lines.sv
module level_lines #(
    parameter int NUM_LVL = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] ext_level,
    output logic [NUM_LVL-1:0] pil_q,
    output logic               wake_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pil_q  <= '0;
            wake_q <= 1'b0;
        end else begin
            pil_q  <= ext_level;
            wake_q <= |(ext_level & ~pil_q);
        end
    end

    // R7
    wake_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> ((pil_q & ~$past(pil_q)) != '0));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import soft_irq_pkg::*;
#(
    parameter int NUM_LVL   = 16,
    parameter int REG_W     = 32,
    parameter int TT_W      = 9,
    parameter int EXT_TT    = 64,
    parameter int TIMER_LVL = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] pil_q,
    input  logic [REG_W-1:0]   sreg_q,
    input  logic               other_post,
    input  logic [TT_W-1:0]    other_idx,
    input  logic               post_clear,
    output logic [TT_W-1:0]    trap_idx,
    output logic               irq_assert,
    output logic               irq_deassert
);

    localparam int LW = $clog2(NUM_LVL);
    localparam logic [TT_W-1:0] EXT_V = TT_W'(EXT_TT);

    logic [REG_W-1:0] pend;
    logic             any_pend;
    logic             found;
    logic [LW-1:0]    win;

    arb_state_e       state_q, state_d;
    logic [LW-1:0]    lvl_q, lvl_d;
    logic [TT_W-1:0]  foreign_q, foreign_d;
    logic             as_d, de_d;

    assign pend = REG_W'(pil_q)
                | (sreg_q & ~REG_W'(1))
                | (REG_W'(sreg_q[0]) << TIMER_LVL);
    assign any_pend = |pend;

    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int i = 1; i < NUM_LVL; i++) begin
            if (pend[i]) begin
                found = 1'b1;
                win   = LW'(i);
            end
        end
    end

    always_comb begin
        state_d   = state_q;
        lvl_d     = lvl_q;
        foreign_d = foreign_q;
        as_d      = 1'b0;
        de_d      = 1'b0;
        if (post_clear) begin
            state_d = ARB_IDLE;
        end else if (other_post) begin
            state_d   = ARB_FOREIGN;
            foreign_d = other_idx;
        end else begin
            unique case (state_q)
                ARB_IDLE: begin
                    if (any_pend && found) begin
                        state_d = ARB_CLAIMED;
                        lvl_d   = win;
                        as_d    = 1'b1;
                    end
                end
                ARB_CLAIMED: begin
                    if (any_pend && found) begin
                        if (win != lvl_q) begin
                            lvl_d = win;
                            as_d  = 1'b1;
                        end
                    end else if (!any_pend) begin
                        state_d = ARB_IDLE;
                        de_d    = 1'b1;
                    end
                end
                ARB_FOREIGN: state_d = ARB_FOREIGN;
                default:     state_d = ARB_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ARB_IDLE;
            lvl_q        <= '0;
            foreign_q    <= '0;
            irq_assert   <= 1'b0;
            irq_deassert <= 1'b0;
        end else begin
            state_q      <= state_d;
            lvl_q        <= lvl_d;
            foreign_q    <= foreign_d;
            irq_assert   <= as_d;
            irq_deassert <= de_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ARB_IDLE:    trap_idx = '0;
            ARB_CLAIMED: trap_idx = EXT_V | TT_W'(lvl_q);
            ARB_FOREIGN: trap_idx = foreign_q;
            default:     trap_idx = '0;
        endcase
    end

    // R11
    foreign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_FOREIGN && !post_clear && !other_post) |=> $stable(trap_idx));

    // R9
    claim_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_assert |-> (trap_idx[TT_W-1:LW] == EXT_V[TT_W-1:LW] && trap_idx[LW-1:0] != '0));

    // R10
    release_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_deassert |-> (trap_idx == '0));

    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_assert && irq_deassert));

endmodule

// File: rtl/soft_irq_ctrl.sv
module soft_irq_ctrl #(
    parameter int REG_W     = 32,
    parameter int SRC_W     = 64,
    parameter int NUM_TICK  = 3,
    parameter int NUM_LVL   = 16,
    parameter int TT_W      = 9,
    parameter int EXT_TT    = 64,
    parameter int TIMER_LVL = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          sw_op,
    input  logic [SRC_W-1:0]    sw_src_a,
    input  logic [SRC_W-1:0]    sw_src_b,
    input  logic                sw_supervisor,
    input  logic [NUM_TICK-1:0] tick_match,
    input  logic [NUM_LVL-1:0]  ext_level,
    input  logic                other_post,
    input  logic [TT_W-1:0]     other_idx,
    input  logic                post_clear,
    output logic [SRC_W-1:0]    rd_data,
    output logic                sw_illegal,
    output logic [TT_W-1:0]     trap_idx,
    output logic                irq_assert,
    output logic                irq_deassert,
    output logic                wake
);

    localparam int EXT_BITS = SRC_W - REG_W;

    logic [REG_W-1:0]   sreg;
    logic [NUM_LVL-1:0] pil;

    softint_reg #(
        .REG_W    (REG_W),
        .SRC_W    (SRC_W),
        .NUM_TICK (NUM_TICK)
    ) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (sw_op),
        .src_a      (sw_src_a),
        .src_b      (sw_src_b),
        .supervisor (sw_supervisor),
        .tick_match (tick_match),
        .sreg_q     (sreg),
        .illegal_q  (sw_illegal)
    );

    level_lines #(
        .NUM_LVL (NUM_LVL)
    ) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_level (ext_level),
        .pil_q     (pil),
        .wake_q    (wake)
    );

    irq_arbiter #(
        .NUM_LVL   (NUM_LVL),
        .REG_W     (REG_W),
        .TT_W      (TT_W),
        .EXT_TT    (EXT_TT),
        .TIMER_LVL (TIMER_LVL)
    ) u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .pil_q        (pil),
        .sreg_q       (sreg),
        .other_post   (other_post),
        .other_idx    (other_idx),
        .post_clear   (post_clear),
        .trap_idx     (trap_idx),
        .irq_assert   (irq_assert),
        .irq_deassert (irq_deassert)
    );

    assign rd_data = {{EXT_BITS{sreg[REG_W-1]}}, sreg};

endmodule

// File: tb/test_soft_irq_ctrl.sv
`timescale 1ns/1ps
module test_soft_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  sw_op = '0;
    logic [63:0] sw_src_a = '0;
    logic [63:0] sw_src_b = '0;
    logic        sw_supervisor = 1'b0;
    logic [2:0]  tick_match = '0;
    logic [15:0] ext_level = '0;
    logic        other_post = 1'b0;
    logic [8:0]  other_idx = '0;
    logic        post_clear = 1'b0;
    logic [63:0] rd_data;
    logic        sw_illegal;
    logic [8:0]  trap_idx;
    logic        irq_assert;
    logic        irq_deassert;
    logic        wake;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    soft_irq_ctrl i_soft_irq_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_op        (sw_op),
        .sw_src_a     (sw_src_a),
        .sw_src_b     (sw_src_b),
        .sw_supervisor(sw_supervisor),
        .tick_match   (tick_match),
        .ext_level    (ext_level),
        .other_post   (other_post),
        .other_idx    (other_idx),
        .post_clear   (post_clear),
        .rd_data      (rd_data),
        .sw_illegal   (sw_illegal),
        .trap_idx     (trap_idx),
        .irq_assert   (irq_assert),
        .irq_deassert (irq_deassert),
        .wake         (wake)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [63:0] a;
        logic [63:0] b;
        logic        sup;
        logic [2:0]  tk;
        logic [15:0] ext;
        logic [63:0] exp_rd;
        logic [8:0]  exp_trap;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 64'h0, 64'h0, 1'b1, 3'b000, 16'h0000, 64'h0, 9'h000},                  // idle
        '{2'd1, 64'h0F0, 64'h0F8, 1'b1, 3'b000, 16'h0000, 64'h8, 9'h043},               // R1 set via xor
        '{2'd1, 64'hFFFF_FFFF_0000_0020, 64'h0, 1'b1, 3'b000, 16'h0000, 64'h28, 9'h045},// R1 truncation
        '{2'd2, 64'h20, 64'h0, 1'b1, 3'b000, 16'h0000, 64'h8, 9'h043},                  // R1 clear
        '{2'd0, 64'h0, 64'h0, 1'b1, 3'b000, 16'h0400, 64'h8, 9'h04A},                   // R6 line wins
        '{2'd0, 64'h0, 64'h0, 1'b1, 3'b001, 16'h0400, 64'h9, 9'h04E},                   // R5 timer level 14
        '{2'd3, 64'h8000_0000, 64'h0, 1'b1, 3'b000, 16'h0400, 64'hFFFF_FFFF_8000_0000, 9'h04A}, // R3 sign ext
        '{2'd0, 64'h0, 64'h0, 1'b1, 3'b000, 16'h0000, 64'hFFFF_FFFF_8000_0000, 9'h04A}, // R8 no level, hold
        '{2'd3, 64'h55, 64'h55, 1'b1, 3'b000, 16'h0000, 64'h0, 9'h000},                 // R10 release
        '{2'd1, 64'hFFFF, 64'h0, 1'b0, 3'b000, 16'h0000, 64'h0, 9'h000},                // R2 unprivileged
        '{2'd0, 64'h0, 64'h0, 1'b1, 3'b000, 16'h0001, 64'h0, 9'h000},                   // R8 bit0 only
        '{2'd0, 64'h0, 64'h0, 1'b1, 3'b100, 16'h8001, 64'h1, 9'h04F},                   // R8 level 15 beats 14
        '{2'd2, 64'h1, 64'h0, 1'b1, 3'b000, 16'h0000, 64'h0, 9'h000}                    // R10 release again
    };

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12", "rd", rd_data, 64'h0);
        chk("R12", "trap", 64'(trap_idx), 64'h0);
        chk("R12", "pulses", {61'h0, irq_assert, irq_deassert, wake}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            sw_op = VECS[v].op; sw_src_a = VECS[v].a; sw_src_b = VECS[v].b;
            sw_supervisor = VECS[v].sup; tick_match = VECS[v].tk; ext_level = VECS[v].ext;
            @(negedge clk);
            sw_op = 2'd0; tick_match = '0;
            @(negedge clk);
            chk("R1/R3", $sformatf("vec%0d rd", v), rd_data, VECS[v].exp_rd);
            chk("R8/R9", $sformatf("vec%0d trap", v), 64'(trap_idx), 64'(VECS[v].exp_trap));
        end

        // R8: register bit above level 15 neither claims
        sw_op = 2'd1; sw_src_a = 64'h1_0000; sw_src_b = 64'h0; sw_supervisor = 1'b1;
        @(negedge clk); sw_op = 2'd0;
        @(negedge clk);
        chk("R8", "high bit rd", rd_data, 64'h1_0000);
        chk("R8", "high bit trap", 64'(trap_idx), 64'h0);

        // R2: unprivileged clear flags illegal, leaves register
        sw_op = 2'd2; sw_supervisor = 1'b0;
        @(negedge clk);
        chk("R2", "illegal", 64'(sw_illegal), 64'h1);
        chk("R2", "rd kept", rd_data, 64'h1_0000);
        sw_op = 2'd0; sw_supervisor = 1'b1;
        @(negedge clk);
        chk("R2", "illegal one cycle", 64'(sw_illegal), 64'h0);

        // R4: tick with write in same cycle keeps timer bit
        sw_op = 2'd3; sw_src_a = 64'h0; tick_match = 3'b010;
        @(negedge clk); sw_op = 2'd0; tick_match = '0;
        chk("R4", "timer wins write", rd_data, 64'h1);
        @(negedge clk);
        chk("R5", "timer level", 64'(trap_idx), 64'h04E);
        sw_op = 2'd2; sw_src_a = 64'h1;
        @(negedge clk); sw_op = 2'd0;
        @(negedge clk);
        chk("R10", "deassert", 64'(irq_deassert), 64'h1);
        chk("R10", "trap zero", 64'(trap_idx), 64'h0);

        // R7/R9: wake and assert pulses
        ext_level = 16'h0004;
        @(negedge clk);
        chk("R7", "wake", 64'(wake), 64'h1);
        chk("R9", "no early assert", 64'(irq_assert), 64'h0);
        @(negedge clk);
        chk("R7", "wake one cycle", 64'(wake), 64'h0);
        chk("R9", "assert", 64'(irq_assert), 64'h1);
        chk("R9", "trap 42", 64'(trap_idx), 64'h042);
        @(negedge clk);
        chk("R9", "no repeat assert", 64'(irq_assert), 64'h0);
        ext_level = 16'h0084;
        @(negedge clk);
        chk("R7", "wake second", 64'(wake), 64'h1);
        @(negedge clk);
        chk("R9", "relevel up", {55'h0, trap_idx}, {55'h0, 9'h047});
        chk("R9", "assert relevel", 64'(irq_assert), 64'h1);
        ext_level = 16'h0004;
        @(negedge clk);
        chk("R7", "no wake on fall", 64'(wake), 64'h0);
        @(negedge clk);
        chk("R6", "relevel down", 64'(trap_idx), 64'h042);
        ext_level = 16'h0000;
        @(negedge clk); @(negedge clk);
        chk("R10", "deassert lines", 64'(irq_deassert), 64'h1);
        @(negedge clk);
        chk("R10", "deassert one cycle", 64'(irq_deassert), 64'h0);

        // R11: foreign trap freezes claim and release
        other_post = 1'b1; other_idx = 9'h024;
        @(negedge clk); other_post = 1'b0;
        chk("R11", "foreign posted", 64'(trap_idx), 64'h024);
        ext_level = 16'h0020;
        @(negedge clk); @(negedge clk);
        chk("R11", "no claim", 64'(trap_idx), 64'h024);
        chk("R11", "no assert", 64'(irq_assert), 64'h0);
        ext_level = 16'h0000;
        @(negedge clk); @(negedge clk);
        chk("R11", "no release", 64'(trap_idx), 64'h024);
        ext_level = 16'h0020; post_clear = 1'b1;
        @(negedge clk); post_clear = 1'b0;
        chk("R11", "cleared", 64'(trap_idx), 64'h0);
        @(negedge clk);
        chk("R11", "claim after clear", 64'(trap_idx), 64'h045);

        // R12: reset mid-run
        ext_level = 16'h0000;
        sw_op = 2'd1; sw_src_a = 64'h300;
        @(negedge clk); sw_op = 2'd0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R12", "rd after reset", rd_data, 64'h0);
        chk("R12", "trap after reset", 64'(trap_idx), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        summary();
    end

endmodule